// File: doc/BRIEF.md
# I/O Window Address Translator

This block is the bridge stage between a processor's memory window and a narrow I/O port bus. A processor request carries a full 32-bit address. If the address falls inside an 8 MB window starting at 0x8000_0000, the block turns the offset within the window into a 16-bit port number and sends the access to the I/O bus one clock later. The access keeps its size (1, 2 or 4 bytes), its direction and its write data. When the I/O bus signals completion, the block returns the read data unchanged.

Two mapping modes are selected by a control input. Linear mode uses the low 16 offset bits directly as the port number. Paged mode gives every 4 KB page of the window its own group of 32 consecutive ports: the page number becomes the upper port bits and the offset's five lowest bits pick the port within the group.

The request side is a valid/ready stream. The requester holds `req_valid` and the request fields stable until `req_ready` is high at a clock edge. Only one access is outstanding at a time, so `req_ready` stays low from acceptance until the completion cycle. The I/O side is valid/ready for issue. The I/O bus then answers with a one-cycle `io_done` strobe. The response is a valid-only pulse with no back-pressure: the requester must take it in the cycle it appears.

Top module: `iowin_xlate`

## Requirements
- R1: `win_hit` is high exactly when `req_valid` is high and `req_addr[31:23]` equals 9'h100, that is, when the address lies in 0x8000_0000 to 0x807F_FFFF inclusive.
- R2: A request whose address is outside the window is consumed and dropped. `req_ready` remains high in the cycle after it is accepted, `io_valid` stays low and no response pulse is produced.
- R3: With `map_mode` = 0 (linear) at acceptance, `io_port` equals bits [15:0] of the request address.
- R4: With `map_mode` = 1 (paged) at acceptance, `io_port[4:0]` equals address bits [4:0] and `io_port[15:5]` equals address bits [22:12]. Address bits [11:5] have no effect on the port.
- R5: `io_size` (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes), `io_write` and `io_wdata` equal the accepted request's size, direction and write data. The translation is the same for every size.
- R6: `io_valid` rises in the cycle after an in-window request is accepted. It stays high, with all `io_*` request fields unchanged, until the clock edge at which `io_ready` is high.
- R7: `map_mode` is sampled only at acceptance. Changing it while an access is in flight does not alter that access's port.
- R8: `rsp_valid` is high in exactly the cycles where `io_done` completes the outstanding access, including the case where `io_done` arrives together with `io_ready`. For a read, `rsp_rdata` equals `io_rdata`; for a write it is zero. `rsp_write` gives the direction.
- R9: `req_ready` is low from the cycle after an in-window acceptance until the completion edge, and high again in the following cycle.
- R10: After reset `req_ready` is high and `io_valid` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| map_mode | input | 1 | Mapping mode: 0 linear, 1 paged |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted at this edge when high with req_valid |
| req_addr | input | 32 | Processor address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data |
| win_hit | output | 1 | Current request falls inside the window |
| io_valid | output | 1 | I/O request valid |
| io_ready | input | 1 | I/O bus takes the request |
| io_port | output | 16 | Translated port number |
| io_write | output | 1 | I/O direction |
| io_size | output | 2 | I/O size code |
| io_wdata | output | 32 | I/O write data |
| io_done | input | 1 | One-cycle completion strobe from the I/O bus |
| io_rdata | input | 32 | Read data from the I/O bus, valid with io_done |
| rsp_valid | output | 1 | Completion pulse to the requester |
| rsp_write | output | 1 | Direction of the completed access |
| rsp_rdata | output | 32 | Returned read data |

## Verification
The assertions assume that the I/O bus raises `io_done` only for an access it has already taken, either in the same cycle as `io_ready` or after it, and never while the block is idle. They also assume the requester keeps its fields stable while waiting. The bench models the I/O bus itself and only ever drives `io_ready` while it expects `io_valid`. It raises `io_done` only once the handshake has happened or together with it, and it holds every request field constant from the moment `req_valid` rises until the acceptance edge.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

  // Access size codes carried unchanged from request to I/O bus
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  // Transfer sequencing
  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_ISSUE = 2'd1,
    XS_WAIT  = 2'd2
  } xfer_state_e;

endpackage

// File: rtl/iowin_decode.sv
module iowin_decode #(
  parameter int              ADDR_W    = 32,
  parameter logic [31:0]     WIN_BASE  = 32'h8000_0000,
  parameter int              WIN_BITS  = 23,
  parameter int              PORT_W    = 16,
  parameter int              GRP_BITS  = 5,
  parameter int              PAGE_BITS = 12
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              paged,
  output logic              hit,
  output logic [PORT_W-1:0] port
);
  localparam int HI_BITS = PORT_W - GRP_BITS;

  logic [WIN_BITS-1:0] offs;
  logic [PORT_W-1:0]   linear_port;
  logic [PORT_W-1:0]   paged_port;

  assign offs = addr[WIN_BITS-1:0];
  assign hit  = valid && (addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);

  generate
    if (WIN_BITS >= PORT_W) begin : g_lin_trunc
      assign linear_port = offs[PORT_W-1:0];
    end else begin : g_lin_ext
      assign linear_port = {{(PORT_W-WIN_BITS){1'b0}}, offs};
    end
  endgenerate

  // page number on top, port-in-group below; middle offset bits dropped
  assign paged_port = {offs[PAGE_BITS+HI_BITS-1:PAGE_BITS], offs[GRP_BITS-1:0]};

  assign port = paged ? paged_port : linear_port;

  initial begin
    assert (PAGE_BITS + HI_BITS <= WIN_BITS && GRP_BITS <= PAGE_BITS)
      else $error("iowin_decode: page field exceeds window");
  end
endmodule

// File: rtl/iowin_issue_reg.sv
module iowin_issue_reg #(
  parameter int PORT_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PORT_W-1:0] port_d,
  input  logic              write_d,
  input  logic [1:0]        size_d,
  input  logic [DATA_W-1:0] wdata_d,
  output logic [PORT_W-1:0] port_q,
  output logic              write_q,
  output logic [1:0]        size_q,
  output logic [DATA_W-1:0] wdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q  <= '0;
      write_q <= 1'b0;
      size_q  <= iowin_pkg::SZ_BYTE;
      wdata_q <= '0;
    end else if (load) begin
      port_q  <= port_d;
      write_q <= write_d;
      size_q  <= size_d;
      wdata_q <= wdata_d;
    end
  end
endmodule

// File: rtl/iowin_ctrl.sv
module iowin_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic win_hit,
  input  logic io_ready,
  input  logic io_done,
  output logic req_ready,
  output logic load,
  output logic io_valid,
  output logic rsp_valid
);
  import iowin_pkg::*;

  xfer_state_e st, st_nxt;

  always_comb begin
    st_nxt = st;
    unique case (st)
      XS_IDLE:  if (win_hit) st_nxt = XS_ISSUE;
      XS_ISSUE: if (io_ready) st_nxt = io_done ? XS_IDLE : XS_WAIT;
      XS_WAIT:  if (io_done) st_nxt = XS_IDLE;
      default:  st_nxt = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= XS_IDLE;
    else        st <= st_nxt;
  end

  assign req_ready = (st == XS_IDLE);
  assign load      = req_ready && win_hit;
  assign io_valid  = (st == XS_ISSUE);
  assign rsp_valid = io_done && ((st == XS_WAIT) || (st == XS_ISSUE && io_ready));

  // R6: issue follows an in-window acceptance by one cycle
  a_r6_issue_next: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && win_hit) |=> io_valid);
  // R6: request held until taken
  a_r6_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !io_ready) |=> io_valid);
  // R2: out-of-window request leaves the block idle
  a_r2_drop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !win_hit) |=> (req_ready && !io_valid));
  // R9: no new acceptance while the I/O request is pending
  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    io_valid |-> !req_ready);
  // R8: completion only for an outstanding access
  a_r8_rsp_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  // R9: idle again right after completion
  a_r9_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);
endmodule

// File: rtl/iowin_xlate.sv
module iowin_xlate #(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] WIN_BASE  = 32'h8000_0000,
  parameter int          WIN_BITS  = 23,
  parameter int          PORT_W    = 16,
  parameter int          GRP_BITS  = 5,
  parameter int          PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              win_hit,
  output logic              io_valid,
  input  logic              io_ready,
  output logic [PORT_W-1:0] io_port,
  output logic              io_write,
  output logic [1:0]        io_size,
  output logic [DATA_W-1:0] io_wdata,
  input  logic              io_done,
  input  logic [DATA_W-1:0] io_rdata,
  output logic              rsp_valid,
  output logic              rsp_write,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int HI_BITS = PORT_W - GRP_BITS;

  logic              load;
  logic [PORT_W-1:0] port_d;

  iowin_decode #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BITS(WIN_BITS),
    .PORT_W(PORT_W), .GRP_BITS(GRP_BITS), .PAGE_BITS(PAGE_BITS)
  ) u_decode (
    .valid (req_valid),
    .addr  (req_addr),
    .paged (map_mode),
    .hit   (win_hit),
    .port  (port_d)
  );

  iowin_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .win_hit   (win_hit),
    .io_ready  (io_ready),
    .io_done   (io_done),
    .req_ready (req_ready),
    .load      (load),
    .io_valid  (io_valid),
    .rsp_valid (rsp_valid)
  );

  iowin_issue_reg #(.PORT_W(PORT_W), .DATA_W(DATA_W)) u_issue (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .port_d  (port_d),
    .write_d (req_write),
    .size_d  (req_size),
    .wdata_d (req_wdata),
    .port_q  (io_port),
    .write_q (io_write),
    .size_q  (io_size),
    .wdata_q (io_wdata)
  );

  assign rsp_write = io_write;
  assign rsp_rdata = (rsp_valid && !io_write) ? io_rdata : '0;

  // R4: paged mode packs page number over low group bits
  a_r4_paged_port: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && win_hit && map_mode) |=>
      (io_port[GRP_BITS-1:0] == $past(req_addr[GRP_BITS-1:0]) &&
       io_port[PORT_W-1:GRP_BITS] == $past(req_addr[PAGE_BITS+HI_BITS-1:PAGE_BITS])));
  // R3: linear mode keeps low offset bits
  a_r3_linear_port: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && win_hit && !map_mode) |=>
      (io_port == $past(req_addr[PORT_W-1:0])));
  // R5: size, direction and data carried across
  a_r5_fields_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && win_hit) |=>
      (io_size == $past(req_size) && io_write == $past(req_write) &&
       io_wdata == $past(req_wdata)));
  // R6, R7: fields frozen while the request waits
  a_r6_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !io_ready) |=>
      ($stable(io_port) && $stable(io_size) && $stable(io_write) && $stable(io_wdata)));
endmodule

// File: tb/tb_iowin_xlate.sv
`timescale 1ns/1ps
module tb_iowin_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        win_hit;
  logic        io_valid;
  logic        io_ready = 1'b0;
  logic [15:0] io_port;
  logic        io_write;
  logic [1:0]  io_size;
  logic [31:0] io_wdata;
  logic        io_done = 1'b0;
  logic [31:0] io_rdata = '0;
  logic        rsp_valid;
  logic        rsp_write;
  logic [31:0] rsp_rdata;

  always #2 clk = ~clk;

  iowin_xlate dut (.*);

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct packed {
    logic [15:0] port;
    logic        wr;
    logic [1:0]  sz;
    logic [31:0] wd;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic logic [15:0] model_port(input logic [31:0] a, input logic md);
    if (md) return {a[22:12], a[4:0]};
    return a[15:0];
  endfunction

  // monitor: compare every I/O handshake with the scoreboard
  always @(negedge clk) begin
    if (rst_n && io_valid && io_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected io request", {16'h0, io_port}, 32'h0);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(io_port == e.port, t, {16'h0, io_port}, {16'h0, e.port});
        check(io_size == e.sz && io_write == e.wr, "R5 size/dir",
              {29'h0, io_write, io_size}, {29'h0, e.wr, e.sz});
        check(io_wdata == e.wd, "R5 wdata", io_wdata, e.wd);
      end
    end
  end

  task automatic do_acc(input logic [31:0] a, input logic wr, input logic [1:0] sz,
                        input logic [31:0] wd, input logic md, input int rdly,
                        input int ddly, input bit flip, input logic [31:0] rd,
                        input string tag);
    bit hit_exp;
    hit_exp = (a[31:23] == 9'h100);
    @(posedge clk); #1;
    map_mode = md; req_valid = 1'b1; req_addr = a; req_write = wr;
    req_size = sz; req_wdata = wd;
    #0.5;
    check(win_hit == hit_exp, "R1 win_hit", {31'h0, win_hit}, {31'h0, hit_exp});
    if (hit_exp) begin
      exp_q.push_back('{port: model_port(a, md), wr: wr, sz: sz, wd: wd});
      tag_q.push_back(tag);
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (flip) map_mode = ~md;
    if (!hit_exp) begin
      for (int k = 0; k < 3; k++) begin
        check(!io_valid && req_ready && !rsp_valid, "R2 dropped",
              {29'h0, io_valid, req_ready, rsp_valid}, 32'h2);
        @(posedge clk); #1;
      end
      return;
    end
    check(io_valid == 1'b1, "R6 io_valid after accept", {31'h0, io_valid}, 32'h1);
    check(req_ready == 1'b0, "R9 busy", {31'h0, req_ready}, 32'h0);
    for (int k = 0; k < rdly; k++) begin
      @(posedge clk); #1;
      check(io_valid && io_port == model_port(a, md), "R6 hold",
            {15'h0, io_valid, io_port}, {15'h0, 1'b1, model_port(a, md)});
    end
    io_ready = 1'b1;
    if (ddly == 0) begin
      io_done = 1'b1; io_rdata = rd; #0.5;
      check(rsp_valid == 1'b1, "R8 rsp with ready", {31'h0, rsp_valid}, 32'h1);
      check(rsp_rdata == (wr ? 32'h0 : rd) && rsp_write == wr, "R8 rdata",
            rsp_rdata, wr ? 32'h0 : rd);
      @(posedge clk); #1;
      io_ready = 1'b0; io_done = 1'b0;
    end else begin
      #0.5;
      check(rsp_valid == 1'b0, "R8 no early rsp", {31'h0, rsp_valid}, 32'h0);
      @(posedge clk); #1;
      io_ready = 1'b0;
      for (int k = 1; k < ddly; k++) begin
        check(!rsp_valid && !req_ready && !io_valid, "R9 wait",
              {29'h0, rsp_valid, req_ready, io_valid}, 32'h0);
        @(posedge clk); #1;
      end
      io_done = 1'b1; io_rdata = rd; #0.5;
      check(rsp_valid == 1'b1, "R8 rsp on done", {31'h0, rsp_valid}, 32'h1);
      check(rsp_rdata == (wr ? 32'h0 : rd) && rsp_write == wr, "R8 rdata",
            rsp_rdata, wr ? 32'h0 : rd);
      @(posedge clk); #1;
      io_done = 1'b0;
    end
    check(req_ready && !io_valid, "R9 ready again",
          {30'h0, req_ready, io_valid}, 32'h2);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog timeout");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(req_ready && !io_valid && !rsp_valid, "R10 reset state",
          {29'h0, req_ready, io_valid, rsp_valid}, 32'h4);
    rst_n = 1'b1;
    // R3 linear mode, several sizes and delays
    do_acc(32'h8000_1234, 1'b0, 2'd0, 32'h0, 1'b0, 0, 2, 0, 32'h0000_00A5, "R3 linear");
    do_acc(32'h8000_FFFC, 1'b1, 2'd2, 32'hDEAD_BEEF, 1'b0, 2, 0, 0, 32'h1111_1111, "R3 linear write");
    do_acc(32'h8012_3456, 1'b0, 2'd1, 32'h0, 1'b0, 1, 1, 0, 32'h0000_BEEF, "R3 high offset dropped");
    // R4 paged mode
    do_acc(32'h807F_F01F, 1'b0, 2'd1, 32'h0, 1'b1, 0, 3, 0, 32'h0000_5A5A, "R4 paged top");
    do_acc(32'h8000_3FE3, 1'b1, 2'd0, 32'h0000_0077, 1'b1, 1, 0, 0, 32'h0, "R4 mid bits ignored");
    do_acc(32'h8000_3003, 1'b1, 2'd0, 32'h0000_0078, 1'b1, 0, 1, 0, 32'h0, "R4 same group");
    do_acc(32'h8040_2A11, 1'b0, 2'd2, 32'h0, 1'b1, 3, 2, 0, 32'hCAFE_F00D, "R4 R5 word read");
    // window edges (R1) and outside accesses (R2)
    do_acc(32'h8000_0000, 1'b0, 2'd0, 32'h0, 1'b0, 0, 1, 0, 32'h0000_0001, "R1 low edge");
    do_acc(32'h807F_FFFF, 1'b0, 2'd0, 32'h0, 1'b1, 0, 1, 0, 32'h0000_0002, "R1 high edge");
    do_acc(32'h7FFF_FFFF, 1'b0, 2'd0, 32'h0, 1'b0, 0, 0, 0, 32'h0, "R2 below");
    do_acc(32'h8080_0000, 1'b1, 2'd2, 32'h1234_5678, 1'b1, 0, 0, 0, 32'h0, "R2 above");
    do_acc(32'h0000_0092, 1'b1, 2'd0, 32'h0000_0001, 1'b0, 0, 0, 0, 32'h0, "R2 low memory");
    // R7 mode flips after acceptance
    do_acc(32'h8005_6789, 1'b0, 2'd1, 32'h0, 1'b1, 2, 2, 1, 32'h0000_4321, "R7 flip to linear");
    do_acc(32'h8005_6789, 1'b1, 2'd2, 32'h0BAD_F00D, 1'b0, 1, 0, 1, 32'h0, "R7 flip to paged");
    map_mode = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R6 all requests issued", exp_q.size(), 32'h0);
    summary();
    $finish;
  end
endmodule